// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide register front end of one interrupt controller. A host talks to it through a one-bit address, a write strobe, a read strobe and an 8-bit data bus. Writes are decoded into three kinds of word: an initialization start, a control word and a command word. A four-step initialization sequence then steers the data-port writes that follow. The decoded results appear as steady control outputs: the mask, the vector base, auto end-of-interrupt, special nesting, the read select, the poll flag and the special mask. Command words appear as a one-cycle strobe that carries the command code and the level.

The priority resolver and the request and in-service registers are outside this block. Their register values and the current winning line come in as inputs. Reads return the request, in-service or mask register. When poll is armed, a read instead returns the poll result. A poll read also sends a clear strobe for the winning line back to the resolver.

Top module: `pic_prog_if`

## Requirements
- R1: After reset every control output, strobe and read-select field is 0, and the sequencer is idle, so a data-port write loads the mask.
- R2: A write at address 0 with bit 4 set is an initialization start. It clears mask, vector base, nesting, auto-EOI, read select, poll and special mask. It pulses `init_stb_o` for one cycle. It records bit 0 as the flag that a mode word will follow, and the next data-port write is taken as the vector base.
- R3: The data-port write after an initialization start sets `vec_base_o` to the data with bits 2:0 forced to 0.
- R4: The data-port write after the vector base changes no output. It arms the mode-word step if the bit 0 flag was set, and otherwise returns the sequencer to idle.
- R5: In the mode-word step, a data-port write sets `nested_o` from bit 4 and `auto_eoi_o` from bit 1, then returns the sequencer to idle.
- R6: While the sequencer is idle, a data-port write loads `mask_o` with the full byte. The mask changes at no other time except through initialization.
- R7: A write at address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 set arms poll. Bit 1 set loads the read select from bit 0. Bit 6 set loads the special mask from bit 5. A field whose enable bit is clear keeps its value.
- R8: A write at address 0 with bits 4 and 3 both clear pulses `cmd_stb_o` for one cycle, with `cmd_code_o` = bits 7:5 and `cmd_level_o` = bits 2:0. No other output changes.
- R9: With poll clear, `rdata_o` returns `isr_i` at address 0 when the read select is 1, `irr_i` at address 0 when it is 0, and `mask_o` at address 1. These values are combinational in the same cycle.
- R10: With poll set, `rdata_o` returns the winning line in bits 2:0 (upper bits 0), or 7 when no line wins, at either address. The read strobe edge clears poll and, if a line won, pulses `pclr_stb_o` for one cycle with that line on `pclr_line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| irr_i | input | 8 | Request register from the resolver |
| isr_i | input | 8 | In-service register from the resolver |
| win_valid_i | input | 1 | A line currently wins priority |
| win_line_i | input | 3 | Winning line number |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Automatic end of interrupt |
| isr_sel_o | output | 1 | Read select, 1 = in-service |
| poll_o | output | 1 | Poll armed |
| spec_mask_o | output | 1 | Special mask mode |
| init_stb_o | output | 1 | Initialization start pulse (resolver clears, output drops) |
| cmd_stb_o | output | 1 | Command word pulse |
| cmd_code_o | output | 3 | Command code |
| cmd_level_o | output | 3 | Command level |
| pclr_stb_o | output | 1 | Poll clear pulse for the resolver |
| pclr_line_o | output | 3 | Line to clear on a poll |

## Verification
Every registered result is due one clock after the write or read edge that causes it. That covers the control fields, the sequencer step and the three strobes, and each strobe stays high for exactly that one cycle. Read data is due in the same cycle as the address, poll state and resolver inputs it depends on. The bench drives its inputs just after the falling edge. It advances a behavioural model on each rising edge and compares every output against the model on the next falling edge, half a cycle after the registers have settled. Targeted checks after each operation sample at that same point.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;
  localparam int BYTE_W    = 8;
  localparam int LINE_W    = 3;
  localparam int CODE_W    = 3;
  localparam int BASE_LSB  = LINE_W;
  localparam int BASE_W    = BYTE_W - BASE_LSB;
  localparam logic [LINE_W-1:0] SPUR_LINE = '1;

  typedef enum logic [1:0] {
    STEP_IDLE    = 2'd0,
    STEP_BASE    = 2'd1,
    STEP_CASCADE = 2'd2,
    STEP_MODE    = 2'd3
  } step_e;
endpackage

// File: rtl/pic_word_decode.sv
module pic_word_decode (
  input  logic addr_i,
  input  logic wr_i,
  input  logic b4_i,
  input  logic b3_i,
  output logic is_init_o,
  output logic is_ctl_o,
  output logic is_cmd_o,
  output logic is_data_o
);
  logic cmd_port;
  assign cmd_port  = wr_i && !addr_i;
  assign is_init_o = cmd_port && b4_i;
  assign is_ctl_o  = cmd_port && !b4_i && b3_i;
  assign is_cmd_o  = cmd_port && !b4_i && !b3_i;
  assign is_data_o = wr_i && addr_i;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_init_i,
  input  logic              is_data_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              b4_i,
  input  logic              b1_i,
  input  logic              b0_i,
  output step_e             step_o,
  output logic              need_mode_o,
  output logic [BYTE_W-1:0] vec_base_o,
  output logic              nested_o,
  output logic              auto_eoi_o,
  output logic              init_stb_o,
  output logic              mask_we_o
);
  step_e             step_q;
  logic              need_mode_q;
  logic [BASE_W-1:0] base_q;
  logic              nested_q, aeoi_q, init_stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= STEP_IDLE;
      need_mode_q <= 1'b0;
      base_q      <= '0;
      nested_q    <= 1'b0;
      aeoi_q      <= 1'b0;
      init_stb_q  <= 1'b0;
    end else begin
      init_stb_q <= 1'b0;
      if (is_init_i) begin
        step_q      <= STEP_BASE;
        need_mode_q <= b0_i;
        base_q      <= '0;
        nested_q    <= 1'b0;
        aeoi_q      <= 1'b0;
        init_stb_q  <= 1'b1;
      end else if (is_data_i) begin
        unique case (step_q)
          STEP_BASE: begin
            base_q <= base_i;
            step_q <= STEP_CASCADE;
          end
          STEP_CASCADE: step_q <= need_mode_q ? STEP_MODE : STEP_IDLE;
          STEP_MODE: begin
            nested_q <= b4_i;
            aeoi_q   <= b1_i;
            step_q   <= STEP_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign step_o      = step_q;
  assign need_mode_o = need_mode_q;
  assign vec_base_o  = {base_q, {BASE_LSB{1'b0}}};
  assign nested_o    = nested_q;
  assign auto_eoi_o  = aeoi_q;
  assign init_stb_o  = init_stb_q;
  assign mask_we_o   = is_data_i && (step_q == STEP_IDLE);
endmodule

// File: rtl/pic_ocw_regs.sv
module pic_ocw_regs
  import pic_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_init_i,
  input  logic              is_ctl_i,
  input  logic              is_cmd_i,
  input  logic              mask_we_i,
  input  logic              rd_i,
  input  logic              win_valid_i,
  input  logic [LINE_W-1:0] win_line_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] mask_o,
  output logic              isr_sel_o,
  output logic              poll_o,
  output logic              spec_mask_o,
  output logic              cmd_stb_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic [LINE_W-1:0] cmd_level_o,
  output logic              pclr_stb_o,
  output logic [LINE_W-1:0] pclr_line_o
);
  logic [BYTE_W-1:0] mask_q;
  logic              sel_q, poll_q, spec_q, cmd_stb_q, pclr_stb_q;
  logic [CODE_W-1:0] code_q;
  logic [LINE_W-1:0] lvl_q, pclr_line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '0;
      sel_q       <= 1'b0;
      poll_q      <= 1'b0;
      spec_q      <= 1'b0;
      cmd_stb_q   <= 1'b0;
      code_q      <= '0;
      lvl_q       <= '0;
      pclr_stb_q  <= 1'b0;
      pclr_line_q <= '0;
    end else begin
      cmd_stb_q  <= 1'b0;
      pclr_stb_q <= 1'b0;
      // poll read side effect; a same-cycle write below takes precedence
      if (rd_i && poll_q) begin
        poll_q <= 1'b0;
        if (win_valid_i) begin
          pclr_stb_q  <= 1'b1;
          pclr_line_q <= win_line_i;
        end
      end
      if (is_init_i) begin
        mask_q <= '0;
        sel_q  <= 1'b0;
        poll_q <= 1'b0;
        spec_q <= 1'b0;
      end else if (mask_we_i) begin
        mask_q <= wdata_i;
      end else if (is_ctl_i) begin
        if (wdata_i[2]) poll_q <= 1'b1;
        if (wdata_i[1]) sel_q  <= wdata_i[0];
        if (wdata_i[6]) spec_q <= wdata_i[5];
      end else if (is_cmd_i) begin
        cmd_stb_q <= 1'b1;
        code_q    <= wdata_i[BYTE_W-1 -: CODE_W];
        lvl_q     <= wdata_i[LINE_W-1:0];
      end
    end
  end

  assign mask_o      = mask_q;
  assign isr_sel_o   = sel_q;
  assign poll_o      = poll_q;
  assign spec_mask_o = spec_q;
  assign cmd_stb_o   = cmd_stb_q;
  assign cmd_code_o  = code_q;
  assign cmd_level_o = lvl_q;
  assign pclr_stb_o  = pclr_stb_q;
  assign pclr_line_o = pclr_line_q;
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
  import pic_prog_pkg::*;
(
  input  logic              addr_i,
  input  logic              poll_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] irr_i,
  input  logic [BYTE_W-1:0] isr_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic              win_valid_i,
  input  logic [LINE_W-1:0] win_line_i,
  output logic [BYTE_W-1:0] rdata_o
);
  always_comb begin
    if (poll_i)
      rdata_o = {{(BYTE_W-LINE_W){1'b0}}, (win_valid_i ? win_line_i : SPUR_LINE)};
    else if (addr_i)
      rdata_o = mask_i;
    else
      rdata_o = sel_i ? isr_i : irr_i;
  end
endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
  import pic_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [BYTE_W-1:0] irr_i,
  input  logic [BYTE_W-1:0] isr_i,
  input  logic              win_valid_i,
  input  logic [LINE_W-1:0] win_line_i,
  output logic [BYTE_W-1:0] mask_o,
  output logic [BYTE_W-1:0] vec_base_o,
  output logic              nested_o,
  output logic              auto_eoi_o,
  output logic              isr_sel_o,
  output logic              poll_o,
  output logic              spec_mask_o,
  output logic              init_stb_o,
  output logic              cmd_stb_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic [LINE_W-1:0] cmd_level_o,
  output logic              pclr_stb_o,
  output logic [LINE_W-1:0] pclr_line_o
);
  logic  is_init, is_ctl, is_cmd, is_data, mask_we, need_mode;
  step_e step_q;

  pic_word_decode u_dec (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .b4_i     (wdata_i[4]),
    .b3_i     (wdata_i[3]),
    .is_init_o(is_init),
    .is_ctl_o (is_ctl),
    .is_cmd_o (is_cmd),
    .is_data_o(is_data)
  );

  pic_init_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .is_init_i  (is_init),
    .is_data_i  (is_data),
    .base_i     (wdata_i[BYTE_W-1:BASE_LSB]),
    .b4_i       (wdata_i[4]),
    .b1_i       (wdata_i[1]),
    .b0_i       (wdata_i[0]),
    .step_o     (step_q),
    .need_mode_o(need_mode),
    .vec_base_o (vec_base_o),
    .nested_o   (nested_o),
    .auto_eoi_o (auto_eoi_o),
    .init_stb_o (init_stb_o),
    .mask_we_o  (mask_we)
  );

  pic_ocw_regs u_ocw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .is_init_i  (is_init),
    .is_ctl_i   (is_ctl),
    .is_cmd_i   (is_cmd),
    .mask_we_i  (mask_we),
    .rd_i       (rd_i),
    .win_valid_i(win_valid_i),
    .win_line_i (win_line_i),
    .wdata_i    (wdata_i),
    .mask_o     (mask_o),
    .isr_sel_o  (isr_sel_o),
    .poll_o     (poll_o),
    .spec_mask_o(spec_mask_o),
    .cmd_stb_o  (cmd_stb_o),
    .cmd_code_o (cmd_code_o),
    .cmd_level_o(cmd_level_o),
    .pclr_stb_o (pclr_stb_o),
    .pclr_line_o(pclr_line_o)
  );

  pic_read_mux u_rd (
    .addr_i     (addr_i),
    .poll_i     (poll_o),
    .sel_i      (isr_sel_o),
    .irr_i      (irr_i),
    .isr_i      (isr_i),
    .mask_i     (mask_o),
    .win_valid_i(win_valid_i),
    .win_line_i (win_line_i),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/pic_prog_if_chk.sv
module pic_prog_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:3] wdata_hi_i,
  input logic [7:0] mask_i,
  input logic [7:0] vec_base_i,
  input logic       poll_i,
  input logic       init_stb_i,
  input logic       cmd_stb_i,
  input logic [1:0] step_i,
  input logic       need_mode_i
);
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i && wdata_hi_i[4] |=> init_stb_i && mask_i == 8'd0 && !poll_i
                                        && vec_base_i == 8'd0 && step_i == 2'd1); // R2
  AST_BASE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i && step_i == 2'd1 |=> vec_base_i[7:3] == $past(wdata_hi_i) && step_i == 2'd2); // R3
  AST_CASCADE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i && step_i == 2'd2 |=> step_i == ($past(need_mode_i) ? 2'd3 : 2'd0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_i)); // R6
  AST_CMD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i |-> $past(wr_i && !addr_i && !wdata_hi_i[4] && !wdata_hi_i[3])); // R8
  AST_POLL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && poll_i && !wr_i |=> !poll_i); // R10
endmodule

bind pic_prog_if pic_prog_if_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_hi_i (wdata_i[7:3]),
  .mask_i     (mask_o),
  .vec_base_i (vec_base_o),
  .poll_i     (poll_o),
  .init_stb_i (init_stb_o),
  .cmd_stb_i  (cmd_stb_o),
  .step_i     (step_q),
  .need_mode_i(need_mode)
);

// File: tb/sim_pic_prog_if.sv
module sim_pic_prog_if;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0, irr = 8'd0, isr = 8'd0;
  logic       win_valid = 1'b0;
  logic [2:0] win_line = 3'd0;
  logic [7:0] rdata, mask, vec_base;
  logic       nested, aeoi, sel, poll, spec, init_stb, cmd_stb, pclr_stb;
  logic [2:0] cmd_code, cmd_level, pclr_line;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_prog_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .isr_i(isr),
    .win_valid_i(win_valid), .win_line_i(win_line), .mask_o(mask),
    .vec_base_o(vec_base), .nested_o(nested), .auto_eoi_o(aeoi),
    .isr_sel_o(sel), .poll_o(poll), .spec_mask_o(spec), .init_stb_o(init_stb),
    .cmd_stb_o(cmd_stb), .cmd_code_o(cmd_code), .cmd_level_o(cmd_level),
    .pclr_stb_o(pclr_stb), .pclr_line_o(pclr_line)
  );

  // behavioural reference model
  int m_mask, m_vec, m_nest, m_aeoi, m_sel, m_poll, m_spec, m_step, m_need;
  int m_istb, m_cstb, m_code, m_lvl, m_pstb, m_pline;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_vec = 0; m_nest = 0; m_aeoi = 0; m_sel = 0; m_poll = 0;
      m_spec = 0; m_step = 0; m_need = 0; m_istb = 0; m_cstb = 0; m_code = 0;
      m_lvl = 0; m_pstb = 0; m_pline = 0;
    end else begin
      m_istb = 0; m_cstb = 0; m_pstb = 0;
      if (rd && m_poll != 0) begin
        m_poll = 0;
        if (win_valid) begin m_pstb = 1; m_pline = win_line; end
      end
      if (wr && !addr) begin
        if (wdata[4]) begin
          m_mask = 0; m_vec = 0; m_nest = 0; m_aeoi = 0; m_sel = 0; m_poll = 0;
          m_spec = 0; m_step = 1; m_need = wdata[0]; m_istb = 1;
        end else if (wdata[3]) begin
          if (wdata[2]) m_poll = 1;
          if (wdata[1]) m_sel = wdata[0];
          if (wdata[6]) m_spec = wdata[5];
        end else begin
          m_cstb = 1; m_code = wdata / 32; m_lvl = wdata % 8;
        end
      end else if (wr && addr) begin
        case (m_step)
          0: m_mask = wdata;
          1: begin m_vec = (wdata / 8) * 8; m_step = 2; end
          2: m_step = (m_need != 0) ? 3 : 0;
          default: begin m_nest = wdata[4]; m_aeoi = wdata[1]; m_step = 0; end
        endcase
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (m_poll != 0) return win_valid ? int'(win_line) : 7;
    if (addr) return m_mask;
    return (m_sel != 0) ? int'(isr) : int'(irr);
  endfunction

  // per-cycle comparison, half a cycle after the registers update
  always @(negedge clk) if (rst_n) begin
    chk(mask, m_mask, "R6 mask");
    chk(vec_base, m_vec, "R3 vec_base");
    chk(nested, m_nest, "R5 nested");
    chk(aeoi, m_aeoi, "R5 auto_eoi");
    chk(sel, m_sel, "R7 isr_sel");
    chk(poll, m_poll, "R7 poll");
    chk(spec, m_spec, "R7 spec_mask");
    chk(init_stb, m_istb, "R2 init_stb");
    chk(cmd_stb, m_cstb, "R8 cmd_stb");
    if (m_cstb != 0) begin
      chk(cmd_code, m_code, "R8 cmd_code");
      chk(cmd_level, m_lvl, "R8 cmd_level");
    end
    chk(pclr_stb, m_pstb, "R10 pclr_stb");
    if (m_pstb != 0) chk(pclr_line, m_pline, "R10 pclr_line");
    chk(rdata, exp_rdata(), (m_poll != 0) ? "R10 rdata" : "R9 rdata");
  end

  task automatic wr_byte(input logic a, input logic [7:0] d);
    @(negedge clk); #1; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); #1; wr = 1'b0;
  endtask

  task automatic rd_byte(input logic a, output logic [7:0] d);
    @(negedge clk); #1; addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); #1; rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk({mask, vec_base}, 16'h0, "R1 mask/vec");
    chk({nested, aeoi, sel, poll, spec, init_stb, cmd_stb, pclr_stb}, 0, "R1 flags");
    wr_byte(1'b1, 8'h3C);
    chk(mask, 8'h3C, "R1 idle step loads mask");
    // R2 init with mode word
    wr_byte(1'b0, 8'h11);
    chk(init_stb, 1, "R2 init pulse");
    chk(mask, 0, "R2 mask cleared");
    wr_byte(1'b1, 8'h4D);
    chk(vec_base, 8'h48, "R3 base low bits zero");
    wr_byte(1'b1, 8'hFF);
    chk({mask, vec_base}, 16'h0048, "R4 cascade word no effect");
    wr_byte(1'b1, 8'h12);
    chk({nested, aeoi}, 2'b11, "R5 mode word");
    wr_byte(1'b1, 8'hA5);
    chk(mask, 8'hA5, "R6 mask load");
    // R4 init without mode word
    wr_byte(1'b0, 8'h10);
    chk({nested, aeoi}, 0, "R2 mode cleared");
    wr_byte(1'b1, 8'hF8);
    wr_byte(1'b1, 8'h00);
    wr_byte(1'b1, 8'h5A);
    chk(mask, 8'h5A, "R4 back to idle");
    chk(vec_base, 8'hF8, "R4 base kept");
    // R7 control words and R9 reads
    irr = 8'h81; isr = 8'h3C;
    wr_byte(1'b0, 8'h0B);
    chk(sel, 1, "R7 select isr");
    rd_byte(1'b0, d); chk(d, 8'h3C, "R9 isr read");
    wr_byte(1'b0, 8'h08);
    chk(sel, 1, "R7 select held");
    wr_byte(1'b0, 8'h0A);
    rd_byte(1'b0, d); chk(d, 8'h81, "R9 irr read");
    rd_byte(1'b1, d); chk(d, 8'h5A, "R9 mask read");
    wr_byte(1'b0, 8'h68); chk(spec, 1, "R7 special mask on");
    wr_byte(1'b0, 8'h28); chk(spec, 1, "R7 special mask held");
    wr_byte(1'b0, 8'h48); chk(spec, 0, "R7 special mask off");
    // R8 commands
    wr_byte(1'b0, 8'hE3);
    chk({cmd_stb, cmd_code, cmd_level}, {1'b1, 3'd7, 3'd3}, "R8 command 7/3");
    chk(mask, 8'h5A, "R8 no side effect");
    wr_byte(1'b0, 8'h25);
    chk({cmd_stb, cmd_code, cmd_level}, {1'b1, 3'd1, 3'd5}, "R8 command 1/5");
    // R10 poll
    win_valid = 1'b1; win_line = 3'd5;
    wr_byte(1'b0, 8'h0C);
    chk(poll, 1, "R7 poll armed");
    rd_byte(1'b1, d); chk(d, 8'h05, "R10 poll winner");
    chk({poll, pclr_stb, pclr_line}, {1'b0, 1'b1, 3'd5}, "R10 poll clear");
    win_valid = 1'b0;
    wr_byte(1'b0, 8'h0C);
    rd_byte(1'b0, d); chk(d, 8'h07, "R10 poll none");
    chk({poll, pclr_stb}, 0, "R10 no clear");
    rd_byte(1'b1, d); chk(d, 8'h5A, "R9 after poll");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule